// File: doc/BRIEF.md
# Dual-Port GPIO Controller with Peripheral Strobe Decode

This block is a register-mapped general-purpose I/O controller holding two ports, called A and D. Each port has an output-value register, an output-enable register and a composed input view. All of these sit on a 32-bit register bus that is addressed in words. The output-value and output-enable registers drive the pad outputs directly. Three bits of the port A output value also act as the control strobes of an attached parallel flash device. A status pin from the flash and the serial data line of an attached sensor appear in the input views.

Port D's output value also drives a bit-banged serial clock. A write that flips the clock bit of that register produces a one-cycle edge event. The event carries the new clock level and the serial data bit written with it, and the attached sensor model uses it to advance.

Two small state machines run the timing. The read-response machine has the states RD_IDLE and RD_RESP. A read request moves it to RD_RESP, and a further read keeps it there. A cycle with no read returns it to RD_IDLE. The edge machine has the states EV_IDLE and EV_EMIT. A toggling write to port D's output value moves it to EV_EMIT, and another toggling write keeps it there. Any other cycle returns it to EV_IDLE.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: While reset is held, every register is zero. This means the output-value and output-enable pad buses read 0, the three flash strobes are low, and both the read-valid and edge-event outputs are low.
- R2: The word index is the byte address shifted right by 2, so the two low address bits are ignored. The port A output value, input view and output enable are at byte addresses 0x00, 0x04 and 0x08. The port D registers are at 0x40, 0x44 and 0x48. An output-value or output-enable register reads back the last value accepted for it.
- R3: Every other word below byte address 0x5C is plain 32-bit read/write storage. This includes the last word, at 0x58.
- R4: A read of a port's input view returns (output value AND output enable) OR the external pin bits.
- R5: In the port A input view, bit 7 is the live flash-ready pin. In the port D input view, bit 4 is the live sensor data pin. Both are sampled in the cycle of the read request.
- R6: Bits 6, 5 and 4 of the port A output value drive the flash address-latch strobe, command-latch strobe and chip-enable strobe, in that order. They take the new value in the cycle after the write.
- R7: A write to port D's output value whose bit 1 differs from the stored bit 1 raises the edge-event valid output for exactly the next cycle. In that cycle the level output equals the new bit 1 and the data output equals the new bit 4. A write that leaves bit 1 unchanged raises no event.
- R8: Two toggling writes on consecutive cycles give two consecutive event cycles, and each cycle carries the level and data of its own write.
- R9: A write whose byte enables are not all ones changes no register and raises no event.
- R10: A read at or above byte address 0x5C returns zero, and a write there changes nothing.
- R11: Read data and read-valid appear in the cycle after the read request, and read-valid lasts one cycle per request. Writes to an input-view address have no effect on any readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_be | input | 4 | Byte enables; only 4'hF writes are accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle per read |
| pa_dout | output | 32 | Port A output value |
| pa_oe | output | 32 | Port A output enable |
| pd_dout | output | 32 | Port D output value |
| pd_oe | output | 32 | Port D output enable |
| flash_ready_i | input | 1 | Flash ready status pin |
| sensor_sdo_i | input | 1 | Serial sensor data pin |
| flash_ale_o | output | 1 | Flash address-latch strobe |
| flash_cle_o | output | 1 | Flash command-latch strobe |
| flash_ce_o | output | 1 | Flash chip-enable strobe |
| sclk_evt_valid | output | 1 | Serial clock edge event |
| sclk_evt_level | output | 1 | New clock level of the event |
| sclk_evt_data | output | 1 | Serial data bit of the event |

## Verification
An edge event can coincide with the capture of the next toggling write. The bench provokes this by issuing two toggling writes to port D's output value on back-to-back cycles. It requires the event to stay high for two cycles, with the first write's level and data in the first cycle and the second write's in the next. A read of an input view can also coincide with a pending event. The bench reads port D's input view right after a toggling write and judges the composed value against the AND/OR rule, using the live sensor pin it drives.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    // Word indices of the named registers
    localparam int PA_DOUT_W = 0;
    localparam int PA_DIN_W  = 1;
    localparam int PA_OE_W   = 2;
    localparam int PD_DOUT_W = 16;
    localparam int PD_DIN_W  = 17;
    localparam int PD_OE_W   = 18;

    // Bit positions decoded by neighbours
    localparam int FLASH_RDY_BIT = 7;
    localparam int SENSOR_DO_BIT = 4;
    localparam int ALE_BIT       = 6;
    localparam int CLE_BIT       = 5;
    localparam int CE_BIT        = 4;
    localparam int SCLK_BIT      = 1;
    localparam int SDAT_BIT      = 4;

    typedef enum logic {
        EV_IDLE = 1'b0,
        EV_EMIT = 1'b1
    } ev_state_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;
endpackage

// File: rtl/gpio_regstore.sv
module gpio_regstore
    import gpio_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 23,
    parameter int IDX_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] words [NUM_WORDS]
);
    // Input-view words hold no storage; every other word is a register.
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        if (i == PA_DIN_W || i == PD_DIN_W) begin : g_view
            assign words[i] = '0;
        end else begin : g_store
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en && wr_idx == IDX_W'(i)) begin
                    q <= wr_data;
                end
            end
            assign words[i] = q;
        end
    end
endmodule

// File: rtl/gpio_readback.sv
module gpio_readback
    import gpio_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 23,
    parameter int IDX_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              rd_in_window,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] words [NUM_WORDS],
    input  logic              flash_ready,
    input  logic              sensor_sdo,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    rd_state_e         state_q, state_d;
    logic [DATA_W-1:0] plain;
    logic [DATA_W-1:0] pins_a, pins_d;
    logic [DATA_W-1:0] composed;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        plain = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                plain = words[i];
            end
        end
    end

    always_comb begin
        pins_a = '0;
        pins_d = '0;
        pins_a[FLASH_RDY_BIT] = flash_ready;
        pins_d[SENSOR_DO_BIT] = sensor_sdo;
    end

    always_comb begin
        if (!rd_in_window) begin
            composed = '0;
        end else if (rd_idx == IDX_W'(PA_DIN_W)) begin
            composed = (words[PA_DOUT_W] & words[PA_OE_W]) | pins_a;
        end else if (rd_idx == IDX_W'(PD_DIN_W)) begin
            composed = (words[PD_DOUT_W] & words[PD_OE_W]) | pins_d;
        end else begin
            composed = plain;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: state_d = rd_req ? RD_RESP : RD_IDLE;
            RD_RESP: state_d = rd_req ? RD_RESP : RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    // State register and data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req) begin
                rdata_q <= composed;
            end
        end
    end

    // Outputs
    always_comb begin
        rvalid = (state_q == RD_RESP);
        rdata  = rdata_q;
    end
endmodule

// File: rtl/gpio_edge_fsm.sv
module gpio_edge_fsm
    import gpio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_clkreg,
    input  logic old_level,
    input  logic new_level,
    input  logic new_data,
    output logic evt_valid,
    output logic evt_level,
    output logic evt_data
);
    ev_state_e state_q, state_d;
    logic      toggle;
    logic      level_q, data_q;

    assign toggle = wr_clkreg && (new_level != old_level);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE: state_d = toggle ? EV_EMIT : EV_IDLE;
            EV_EMIT: state_d = toggle ? EV_EMIT : EV_IDLE;
            default: state_d = EV_IDLE;
        endcase
    end

    // State register and payload capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EV_IDLE;
            level_q <= 1'b0;
            data_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (toggle) begin
                level_q <= new_level;
                data_q  <= new_data;
            end
        end
    end

    // Outputs
    always_comb begin
        evt_valid = (state_q == EV_EMIT);
        evt_level = evt_valid & level_q;
        evt_data  = evt_valid & data_q;
    end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 32,
    parameter int WINDOW_BYTES = 92
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_rvalid,
    output logic [DATA_W-1:0]   pa_dout,
    output logic [DATA_W-1:0]   pa_oe,
    output logic [DATA_W-1:0]   pd_dout,
    output logic [DATA_W-1:0]   pd_oe,
    input  logic                flash_ready_i,
    input  logic                sensor_sdo_i,
    output logic                flash_ale_o,
    output logic                flash_cle_o,
    output logic                flash_ce_o,
    output logic                sclk_evt_valid,
    output logic                sclk_evt_level,
    output logic                sclk_evt_data
);
    localparam int IDX_W     = ADDR_W - 2;
    localparam int NUM_WORDS = WINDOW_BYTES / 4;

    logic [IDX_W-1:0]  idx;
    logic              in_window;
    logic              wr_ok;
    logic              rd_req;
    logic              wr_clkreg;
    logic [DATA_W-1:0] words [NUM_WORDS];

    assign idx       = bus_addr[ADDR_W-1:2];
    assign in_window = int'(bus_addr) < WINDOW_BYTES;
    assign wr_ok     = bus_req && bus_we && (bus_be == '1) && in_window;
    assign rd_req    = bus_req && !bus_we;
    assign wr_clkreg = wr_ok && (idx == IDX_W'(PD_DOUT_W));

    gpio_regstore #(
        .DATA_W    (DATA_W),
        .NUM_WORDS (NUM_WORDS),
        .IDX_W     (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok),
        .wr_idx  (idx),
        .wr_data (bus_wdata),
        .words   (words)
    );

    gpio_readback #(
        .DATA_W    (DATA_W),
        .NUM_WORDS (NUM_WORDS),
        .IDX_W     (IDX_W)
    ) u_read (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_req       (rd_req),
        .rd_in_window (in_window),
        .rd_idx       (idx),
        .words        (words),
        .flash_ready  (flash_ready_i),
        .sensor_sdo   (sensor_sdo_i),
        .rdata        (bus_rdata),
        .rvalid       (bus_rvalid)
    );

    gpio_edge_fsm u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_clkreg (wr_clkreg),
        .old_level (words[PD_DOUT_W][SCLK_BIT]),
        .new_level (bus_wdata[SCLK_BIT]),
        .new_data  (bus_wdata[SDAT_BIT]),
        .evt_valid (sclk_evt_valid),
        .evt_level (sclk_evt_level),
        .evt_data  (sclk_evt_data)
    );

    assign pa_dout     = words[PA_DOUT_W];
    assign pa_oe       = words[PA_OE_W];
    assign pd_dout     = words[PD_DOUT_W];
    assign pd_oe       = words[PD_OE_W];
    assign flash_ale_o = words[PA_DOUT_W][ALE_BIT];
    assign flash_cle_o = words[PA_DOUT_W][CLE_BIT];
    assign flash_ce_o  = words[PA_DOUT_W][CE_BIT];
endmodule

// File: rtl/gpio_pin_ctrl_chk.sv
module gpio_pin_ctrl_chk
    import gpio_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 32,
    parameter int WINDOW_BYTES = 92
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_req,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W/8-1:0] bus_be,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic                bus_rvalid,
    input logic [DATA_W-1:0]   pa_dout,
    input logic [DATA_W-1:0]   pa_oe,
    input logic [DATA_W-1:0]   pd_dout,
    input logic [DATA_W-1:0]   pd_oe,
    input logic                flash_ale_o,
    input logic                flash_cle_o,
    input logic                flash_ce_o,
    input logic                sclk_evt_valid,
    input logic                sclk_evt_level,
    input logic                sclk_evt_data
);
    localparam int IDX_W = ADDR_W - 2;

    logic full_wr, wr_a, wr_d, rd_out;
    assign full_wr = bus_req && bus_we && (bus_be == '1) && (int'(bus_addr) < WINDOW_BYTES);
    assign wr_a    = full_wr && (bus_addr[ADDR_W-1:2] == IDX_W'(PA_DOUT_W));
    assign wr_d    = full_wr && (bus_addr[ADDR_W-1:2] == IDX_W'(PD_DOUT_W));
    assign rd_out  = bus_req && !bus_we && (int'(bus_addr) >= WINDOW_BYTES);

    // R2
    pd_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_d |=> pd_dout == $past(bus_wdata));

    // R6
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_a |=> (flash_ale_o == $past(bus_wdata[ALE_BIT]) &&
                  flash_cle_o == $past(bus_wdata[CLE_BIT]) &&
                  flash_ce_o  == $past(bus_wdata[CE_BIT])));

    // R7
    evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_evt_valid |-> $past(wr_d && (bus_wdata[SCLK_BIT] != pd_dout[SCLK_BIT])));

    // R7
    evt_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_evt_valid |-> (sclk_evt_level == pd_dout[SCLK_BIT] &&
                            sclk_evt_data  == pd_dout[SDAT_BIT]));

    // R9
    partial_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_be != '1) |=>
            ($stable(pa_dout) && $stable(pd_dout) && $stable(pa_oe) &&
             $stable(pd_oe) && !sclk_evt_valid));

    // R10
    outside_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_out |=> bus_rdata == '0);

    // R11
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    // R11
    resp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_req && !bus_we));
endmodule

bind gpio_pin_ctrl gpio_pin_ctrl_chk #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .WINDOW_BYTES (WINDOW_BYTES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_req        (bus_req),
    .bus_we         (bus_we),
    .bus_addr       (bus_addr),
    .bus_be         (bus_be),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .bus_rvalid     (bus_rvalid),
    .pa_dout        (pa_dout),
    .pa_oe          (pa_oe),
    .pd_dout        (pd_dout),
    .pd_oe          (pd_oe),
    .flash_ale_o    (flash_ale_o),
    .flash_cle_o    (flash_cle_o),
    .flash_ce_o     (flash_ce_o),
    .sclk_evt_valid (sclk_evt_valid),
    .sclk_evt_level (sclk_evt_level),
    .sclk_evt_data  (sclk_evt_data)
);

// File: tb/gpio_pin_ctrl_test.sv
module gpio_pin_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [31:0] pa_dout, pa_oe, pd_dout, pd_oe;
    logic        flash_ready_i = 1'b0;
    logic        sensor_sdo_i = 1'b0;
    logic        flash_ale_o, flash_cle_o, flash_ce_o;
    logic        sclk_evt_valid, sclk_evt_level, sclk_evt_data;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_pin_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .pa_dout(pa_dout), .pa_oe(pa_oe), .pd_dout(pd_dout), .pd_oe(pd_oe),
        .flash_ready_i(flash_ready_i), .sensor_sdo_i(sensor_sdo_i),
        .flash_ale_o(flash_ale_o), .flash_cle_o(flash_cle_o), .flash_ce_o(flash_ce_o),
        .sclk_evt_valid(sclk_evt_valid), .sclk_evt_level(sclk_evt_level),
        .sclk_evt_data(sclk_evt_data)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        we;
        logic [7:0]  addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic        frdy;
        logic        sdo;
        logic [31:0] expd;
    } vec_t;

    // fields: requirement, we, addr, be, wdata, flash_ready, sensor_sdo, expected read
    localparam logic [82:0] VECS [NV] = '{
        {4'd2,  1'b1, 8'h00, 4'hF, 32'h0000_00F0, 1'b0, 1'b0, 32'h0},          // R2
        {4'd2,  1'b1, 8'h08, 4'hF, 32'h0000_0030, 1'b0, 1'b0, 32'h0},          // R2
        {4'd4,  1'b0, 8'h04, 4'hF, 32'h0,         1'b0, 1'b0, 32'h0000_0030},  // R4
        {4'd5,  1'b0, 8'h04, 4'hF, 32'h0,         1'b1, 1'b0, 32'h0000_00B0},  // R5
        {4'd2,  1'b0, 8'h00, 4'hF, 32'h0,         1'b0, 1'b0, 32'h0000_00F0},  // R2
        {4'd2,  1'b0, 8'h08, 4'hF, 32'h0,         1'b0, 1'b0, 32'h0000_0030},  // R2
        {4'd2,  1'b1, 8'h40, 4'hF, 32'h0000_0012, 1'b0, 1'b0, 32'h0},          // R2
        {4'd2,  1'b1, 8'h48, 4'hF, 32'h0000_0002, 1'b0, 1'b0, 32'h0},          // R2
        {4'd4,  1'b0, 8'h44, 4'hF, 32'h0,         1'b0, 1'b0, 32'h0000_0002},  // R4
        {4'd5,  1'b0, 8'h44, 4'hF, 32'h0,         1'b0, 1'b1, 32'h0000_0012},  // R5
        {4'd2,  1'b0, 8'h40, 4'hF, 32'h0,         1'b0, 1'b0, 32'h0000_0012},  // R2
        {4'd3,  1'b1, 8'h4C, 4'hF, 32'hDEAD_BEEF, 1'b0, 1'b0, 32'h0},          // R3
        {4'd3,  1'b0, 8'h4C, 4'hF, 32'h0,         1'b0, 1'b0, 32'hDEAD_BEEF},  // R3
        {4'd2,  1'b0, 8'h4E, 4'hF, 32'h0,         1'b0, 1'b0, 32'hDEAD_BEEF},  // R2
        {4'd3,  1'b1, 8'h58, 4'hF, 32'hA5A5_0001, 1'b0, 1'b0, 32'h0},          // R3
        {4'd3,  1'b0, 8'h58, 4'hF, 32'h0,         1'b0, 1'b0, 32'hA5A5_0001},  // R3
        {4'd10, 1'b0, 8'h5C, 4'hF, 32'h0,         1'b0, 1'b0, 32'h0},          // R10
        {4'd10, 1'b1, 8'hF0, 4'hF, 32'h1234_5678, 1'b0, 1'b0, 32'h0},          // R10
        {4'd10, 1'b0, 8'hF0, 4'hF, 32'h0,         1'b0, 1'b0, 32'h0},          // R10
        {4'd9,  1'b1, 8'h00, 4'h7, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0},          // R9
        {4'd9,  1'b0, 8'h00, 4'hF, 32'h0,         1'b0, 1'b0, 32'h0000_00F0},  // R9
        {4'd11, 1'b1, 8'h04, 4'hF, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0},          // R11
        {4'd11, 1'b0, 8'h04, 4'hF, 32'h0,         1'b0, 1'b0, 32'h0000_0030},  // R11
        {4'd11, 1'b0, 8'h48, 4'hF, 32'h0,         1'b0, 1'b0, 32'h0000_0002}   // R11
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Drives one access for one cycle; returns at the negedge after the capturing edge.
    task automatic op(input logic we, input logic [7:0] a, input logic [3:0] be,
                      input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pa_dout == 0 && pa_oe == 0 && pd_dout == 0 && pd_oe == 0, "R1 regs", pa_dout | pd_dout, 0);
        chk({flash_ale_o, flash_cle_o, flash_ce_o} == 3'b000, "R1 strobes",
            {29'd0, flash_ale_o, flash_cle_o, flash_ce_o}, 0);
        chk(!sclk_evt_valid && !bus_rvalid, "R1 valids", {30'd0, sclk_evt_valid, bus_rvalid}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = vec_t'(VECS[i]);
            flash_ready_i = v.frdy;
            sensor_sdo_i  = v.sdo;
            op(v.we, v.addr, v.be, v.wdata);
            if (!v.we) begin
                checks++;
                if (!bus_rvalid || bus_rdata !== v.expd) begin
                    fails++;
                    $display("FAIL R%0d table[%0d] actual=%h/%b expected=%h/1",
                             v.req, i, bus_rdata, bus_rvalid, v.expd);
                end
            end
        end
        flash_ready_i = 1'b0;
        sensor_sdo_i  = 1'b0;

        // R11 read-valid lasts one cycle
        op(1'b0, 8'h00, 4'hF, 0);
        @(negedge clk);
        chk(!bus_rvalid, "R11 rvalid single", {31'd0, bus_rvalid}, 0);

        // R6 strobes
        op(1'b1, 8'h00, 4'hF, 32'h40);
        chk({flash_ale_o, flash_cle_o, flash_ce_o} == 3'b100, "R6 ale",
            {29'd0, flash_ale_o, flash_cle_o, flash_ce_o}, 32'h4);
        op(1'b1, 8'h00, 4'hF, 32'h20);
        chk({flash_ale_o, flash_cle_o, flash_ce_o} == 3'b010, "R6 cle",
            {29'd0, flash_ale_o, flash_cle_o, flash_ce_o}, 32'h2);
        op(1'b1, 8'h00, 4'hF, 32'h10);
        chk({flash_ale_o, flash_cle_o, flash_ce_o} == 3'b001, "R6 ce",
            {29'd0, flash_ale_o, flash_cle_o, flash_ce_o}, 32'h1);

        // R7 edge events; port D output value is 0x12 (clock bit high)
        op(1'b1, 8'h40, 4'hF, 32'h00);
        chk(sclk_evt_valid && !sclk_evt_level && !sclk_evt_data, "R7 falling",
            {29'd0, sclk_evt_valid, sclk_evt_level, sclk_evt_data}, 32'h4);
        @(negedge clk);
        chk(!sclk_evt_valid, "R7 one cycle", {31'd0, sclk_evt_valid}, 0);
        op(1'b1, 8'h40, 4'hF, 32'h10);
        chk(!sclk_evt_valid, "R7 no toggle", {31'd0, sclk_evt_valid}, 0);
        op(1'b1, 8'h40, 4'hF, 32'h12);
        chk(sclk_evt_valid && sclk_evt_level && sclk_evt_data, "R7 rising",
            {29'd0, sclk_evt_valid, sclk_evt_level, sclk_evt_data}, 32'h7);
        // Input view read while the event is pending
        sensor_sdo_i = 1'b1;
        op(1'b0, 8'h44, 4'hF, 0);
        chk(bus_rdata == 32'h12, "R5 read near event", bus_rdata, 32'h12);
        sensor_sdo_i = 1'b0;

        // R9 partial write to port D output value: no event, no change
        op(1'b1, 8'h40, 4'h3, 32'h00);
        chk(!sclk_evt_valid, "R9 no event", {31'd0, sclk_evt_valid}, 0);
        op(1'b0, 8'h40, 4'hF, 0);
        chk(bus_rdata == 32'h12, "R9 unchanged", bus_rdata, 32'h12);

        // R8 back-to-back toggling writes
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 8'h40; bus_be = 4'hF; bus_wdata = 32'h10;
        @(negedge clk);
        bus_wdata = 32'h02;
        chk(sclk_evt_valid && !sclk_evt_level && sclk_evt_data, "R8 first",
            {29'd0, sclk_evt_valid, sclk_evt_level, sclk_evt_data}, 32'h5);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        chk(sclk_evt_valid && sclk_evt_level && !sclk_evt_data, "R8 second",
            {29'd0, sclk_evt_valid, sclk_evt_level, sclk_evt_data}, 32'h6);
        @(negedge clk);
        chk(!sclk_evt_valid, "R8 ends", {31'd0, sclk_evt_valid}, 0);

        // R1 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk(pa_dout == 0 && pd_dout == 0 && pa_oe == 0 && pd_oe == 0, "R1 mid reset",
            pa_dout | pd_dout | pa_oe | pd_oe, 0);
        rst_n = 1'b1;
        op(1'b0, 8'h4C, 4'hF, 0);
        chk(bus_rdata == 0, "R1 storage cleared", bus_rdata, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule